// File: doc/BRIEF.md
# Trap Entry and Interrupt Arbitration Unit

This unit sits beside the execute stage of a core with user, supervisor and machine privilege levels. Each cycle it looks at a synchronous exception request and at the interrupt lines. If one of them is to be taken, it selects it and produces the architectural state the core must adopt. That state is the new program counter and privilege, the cause, return-address and faulting-address registers of the target level, the rewritten status fields, and a pulse that tells the translation cache to flush.

The core passes in its current privilege, its status fields, the two trap vectors, the two delegation masks and the PC to be saved. All results are registered and appear one clock after the request. A breakpoint raised while an external debugger is attached does not take a normal trap. The unit enters debug mode instead: it records why and from where, and jumps to a fixed debug ROM address.

The status vector is 7 bits: bit 0 supervisor interrupt enable (SIE), bit 1 machine interrupt enable (MIE), bit 2 supervisor previous enable (SPIE), bit 3 machine previous enable (MPIE), bit 4 supervisor previous privilege (SPP), bits 6:5 machine previous privilege (MPP). Privilege codes are U=0, S=1, M=3.

Top module: `trap_entry`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs reset as follows. `priv_o` is 3 and `status_o` is 0. `trap_o`, `dbg_enter_o` and `tlb_flush_o` are 0. All cause, return-address, bad-address, debug and PC outputs are 0.
- R2: An interrupt line n is a candidate when `irq_pend_i[n] & irq_en_i[n]`. With `irq_deleg_i[n]`=0 it is eligible only when `priv_i` is below 3, or when `priv_i` is 3 and status bit 1 (MIE) is set.
- R3: A candidate line with `irq_deleg_i[n]`=1 is eligible only when `priv_i` is 0, or when `priv_i` is 1 and status bit 0 (SIE) is set. At privilege 3 it is never taken.
- R4: Among eligible lines the lowest-numbered one wins. Its cause value has bit XLEN-1 set and the line number in the low bits.
- R5: An exception request (`exc_req_i`) is always taken in the cycle after it is presented, and it has precedence over any eligible interrupt in the same cycle. `trap_o` pulses for one cycle for every trap or debug entry.
- R6: A trap goes to supervisor only when `priv_i` is 0 or 1, the cause index (for an interrupt, the line number) is below XLEN, and the matching bit of the delegation mask is 1. The mask is `exc_deleg_i` for exceptions and `irq_deleg_i` for interrupts. Every other trap goes to machine.
- R7: A supervisor trap makes the following updates. `pc_o` becomes `stvec_i`, `scause_o` the cause, `sepc_o` becomes `epc_i` and `priv_o` becomes 1. In the status, SPIE receives the enable of the prior privilege (MIE at 3, SIE at 1, 0 at 0), SPP receives bit 0 of the prior privilege, and SIE is cleared. All other status bits and the machine registers are unchanged.
- R8: A machine trap makes the following updates. `pc_o` becomes `mtvec_i`, `mcause_o` the cause, `mepc_o` becomes `epc_i` and `priv_o` becomes 3. In the status, MPIE receives the prior-privilege enable, MPP the prior privilege, and MIE is cleared. The supervisor registers are unchanged.
- R9: The bad-address register of the target level takes `exc_addr_i` only for an exception with `exc_has_addr_i`=1. Otherwise it holds its value.
- R10: An exception with cause 3 while `dbg_attached_i` is 1 enters debug mode. The unit pulses `dbg_enter_o`, sets `dbg_cause_o`=1, loads `dbg_prv_o` with the prior privilege and `dpc_o` with `epc_i`, and sets `priv_o`=3 and `pc_o`=DBG_ROM. Status, cause, return-address and bad-address outputs stay unchanged.
- R11: `tlb_flush_o` pulses exactly when a trap or debug entry changes the privilege from `priv_i`.
- R12: In a cycle without a trap, `priv_o` and `status_o` follow `priv_i` and `status_i` one cycle later. `pc_o` and all trap registers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_i | input | 2 | Current privilege |
| status_i | input | 7 | Current status fields |
| irq_pend_i | input | NIRQ | Pending interrupt lines |
| irq_en_i | input | NIRQ | Interrupt enables |
| irq_deleg_i | input | NIRQ | Interrupt delegation mask |
| exc_deleg_i | input | XLEN | Exception delegation mask |
| mtvec_i | input | XLEN | Machine trap vector |
| stvec_i | input | XLEN | Supervisor trap vector |
| epc_i | input | XLEN | PC to save on entry |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_cause_i | input | CW | Exception cause index |
| exc_has_addr_i | input | 1 | Exception carries a faulting address |
| exc_addr_i | input | XLEN | Faulting address |
| dbg_attached_i | input | 1 | External debugger attached |
| trap_o | output | 1 | Trap or debug entry taken |
| pc_o | output | XLEN | New program counter |
| priv_o | output | 2 | New privilege |
| status_o | output | 7 | Updated status fields |
| mcause_o | output | XLEN | Machine cause |
| mepc_o | output | XLEN | Machine return address |
| mbad_o | output | XLEN | Machine bad address |
| scause_o | output | XLEN | Supervisor cause |
| sepc_o | output | XLEN | Supervisor return address |
| sbad_o | output | XLEN | Supervisor bad address |
| dbg_enter_o | output | 1 | Debug mode entered |
| dbg_cause_o | output | 3 | Debug entry reason |
| dbg_prv_o | output | 2 | Privilege before debug entry |
| dpc_o | output | XLEN | Debug return PC |
| tlb_flush_o | output | 1 | Translation flush pulse |

## Verification
The bench aims at these corner cases:
- Several lines pending at once. A reversed priority scan would report the highest line instead of the lowest.
- A delegated interrupt at machine level. A unit that ignored the privilege gate would send it to supervisor.
- An exception index of 32 or more with every delegation bit set. Without the range check the index would alias a low mask bit and trap to supervisor.
- An exception and an interrupt in the same cycle, where the wrong precedence records an interrupt cause.
- Breakpoints with and without an attached debugger.
- Exceptions without an address, which must leave the bad-address register intact.
- Traps that keep the same privilege, which must not flush.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int ST_W    = 7;
  localparam int ST_SIE  = 0;
  localparam int ST_MIE  = 1;
  localparam int ST_SPIE = 2;
  localparam int ST_MPIE = 3;
  localparam int ST_SPP  = 4;
  localparam int ST_MPP  = 5;

  localparam logic [2:0] DBG_WHY_SWBP = 3'd1;

  // enable bit that belongs to the privilege being left
  function automatic logic prior_ie(input logic [1:0] p, input logic [ST_W-1:0] st);
    case (p)
      PRIV_M:  return st[ST_MIE];
      PRIV_S:  return st[ST_SIE];
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/trap_irq_pick.sv
module trap_irq_pick
  import trap_pkg::*;
#(
  parameter int NIRQ = 12,
  parameter int IW   = 4
) (
  input  logic [NIRQ-1:0] pend,
  input  logic [NIRQ-1:0] en,
  input  logic [NIRQ-1:0] deleg,
  input  logic [1:0]      priv,
  input  logic            mie,
  input  logic            sie,
  output logic            any,
  output logic [IW-1:0]   idx
);
  logic m_ok, s_ok;
  logic [NIRQ-1:0] elig;

  assign m_ok = (priv != PRIV_M) || mie;
  assign s_ok = (priv == PRIV_U) || ((priv == PRIV_S) && sie);

  for (genvar g = 0; g < NIRQ; g++) begin : g_line
    assign elig[g] = pend[g] & en[g] & (deleg[g] ? s_ok : m_ok);
  end

  always_comb begin
    idx = '0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (elig[i]) idx = IW'(i);
    end
  end

  assign any = |elig;
endmodule

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int CW   = 6
) (
  input  logic            is_irq,
  input  logic [CW-1:0]   idx,
  input  logic [XLEN-1:0] irq_mask,
  input  logic [XLEN-1:0] exc_mask,
  input  logic [1:0]      priv,
  output logic            to_super
);
  localparam int XW = $clog2(XLEN);
  localparam int WW = XW + CW;

  logic [WW-1:0]   wide;
  logic            in_rng;
  logic [XLEN-1:0] mask;

  assign wide   = {{XW{1'b0}}, idx};
  assign in_rng = wide < WW'(XLEN);
  assign mask   = is_irq ? irq_mask : exc_mask;
  assign to_super = ((priv == PRIV_U) || (priv == PRIV_S)) && in_rng && mask[wide[XW-1:0]];
endmodule

// File: rtl/trap_entry.sv
module trap_entry
  import trap_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter int              NIRQ    = 12,
  parameter int              CW      = 6,
  parameter int              BKPT    = 3,
  parameter logic [XLEN-1:0] DBG_ROM = 'h800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        priv_i,
  input  logic [6:0]        status_i,
  input  logic [NIRQ-1:0]   irq_pend_i,
  input  logic [NIRQ-1:0]   irq_en_i,
  input  logic [NIRQ-1:0]   irq_deleg_i,
  input  logic [XLEN-1:0]   exc_deleg_i,
  input  logic [XLEN-1:0]   mtvec_i,
  input  logic [XLEN-1:0]   stvec_i,
  input  logic [XLEN-1:0]   epc_i,
  input  logic              exc_req_i,
  input  logic [CW-1:0]     exc_cause_i,
  input  logic              exc_has_addr_i,
  input  logic [XLEN-1:0]   exc_addr_i,
  input  logic              dbg_attached_i,
  output logic              trap_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [1:0]        priv_o,
  output logic [6:0]        status_o,
  output logic [XLEN-1:0]   mcause_o,
  output logic [XLEN-1:0]   mepc_o,
  output logic [XLEN-1:0]   mbad_o,
  output logic [XLEN-1:0]   scause_o,
  output logic [XLEN-1:0]   sepc_o,
  output logic [XLEN-1:0]   sbad_o,
  output logic              dbg_enter_o,
  output logic [2:0]        dbg_cause_o,
  output logic [1:0]        dbg_prv_o,
  output logic [XLEN-1:0]   dpc_o,
  output logic              tlb_flush_o
);
  localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

  logic            irq_any;
  logic [IW-1:0]   irq_idx;
  logic            dbg_take, irq_take, exc_norm, trap_norm, to_super;
  logic [CW-1:0]   route_idx;
  logic [XLEN-1:0] cause_val;
  logic [1:0]      next_priv;
  logic [ST_W-1:0] next_st;
  logic            pie;

  trap_irq_pick #(.NIRQ(NIRQ), .IW(IW)) u_pick (
    .pend (irq_pend_i),
    .en   (irq_en_i),
    .deleg(irq_deleg_i),
    .priv (priv_i),
    .mie  (status_i[ST_MIE]),
    .sie  (status_i[ST_SIE]),
    .any  (irq_any),
    .idx  (irq_idx)
  );

  assign route_idx = exc_req_i ? exc_cause_i : CW'(irq_idx);

  trap_route #(.XLEN(XLEN), .CW(CW)) u_route (
    .is_irq  (!exc_req_i),
    .idx     (route_idx),
    .irq_mask({{(XLEN-NIRQ){1'b0}}, irq_deleg_i}),
    .exc_mask(exc_deleg_i),
    .priv    (priv_i),
    .to_super(to_super)
  );

  assign dbg_take  = exc_req_i && (exc_cause_i == CW'(BKPT)) && dbg_attached_i;
  assign exc_norm  = exc_req_i && !dbg_take;
  assign irq_take  = !exc_req_i && irq_any;
  assign trap_norm = exc_norm || irq_take;
  assign cause_val = exc_req_i ? XLEN'(exc_cause_i)
                               : {1'b1, {(XLEN-1-IW){1'b0}}, irq_idx};
  assign pie = prior_ie(priv_i, status_i);

  always_comb begin
    next_st   = status_i;
    next_priv = priv_i;
    if (dbg_take) begin
      next_priv = PRIV_M;
    end else if (trap_norm && to_super) begin
      next_st[ST_SPIE] = pie;
      next_st[ST_SPP]  = priv_i[0];
      next_st[ST_SIE]  = 1'b0;
      next_priv        = PRIV_S;
    end else if (trap_norm) begin
      next_st[ST_MPIE]       = pie;
      next_st[ST_MPP +: 2]   = priv_i;
      next_st[ST_MIE]        = 1'b0;
      next_priv              = PRIV_M;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_o      <= 1'b0;
      pc_o        <= '0;
      priv_o      <= PRIV_M;
      status_o    <= '0;
      mcause_o    <= '0;
      mepc_o      <= '0;
      mbad_o      <= '0;
      scause_o    <= '0;
      sepc_o      <= '0;
      sbad_o      <= '0;
      dbg_enter_o <= 1'b0;
      dbg_cause_o <= '0;
      dbg_prv_o   <= '0;
      dpc_o       <= '0;
      tlb_flush_o <= 1'b0;
    end else begin
      trap_o      <= trap_norm || dbg_take;
      dbg_enter_o <= dbg_take;
      priv_o      <= next_priv;
      status_o    <= next_st;
      tlb_flush_o <= (trap_norm || dbg_take) && (next_priv != priv_i);
      if (dbg_take) begin
        pc_o        <= DBG_ROM;
        dbg_cause_o <= DBG_WHY_SWBP;
        dbg_prv_o   <= priv_i;
        dpc_o       <= epc_i;
      end else if (trap_norm && to_super) begin
        pc_o     <= stvec_i;
        scause_o <= cause_val;
        sepc_o   <= epc_i;
        if (exc_req_i && exc_has_addr_i) sbad_o <= exc_addr_i;
      end else if (trap_norm) begin
        pc_o     <= mtvec_i;
        mcause_o <= cause_val;
        mepc_o   <= epc_i;
        if (exc_req_i && exc_has_addr_i) mbad_o <= exc_addr_i;
      end
    end
  end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
  import trap_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter logic [XLEN-1:0] DBG_ROM = 'h800
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      priv_i,
  input logic [6:0]      status_i,
  input logic            exc_req_i,
  input logic            trap_o,
  input logic [XLEN-1:0] pc_o,
  input logic [1:0]      priv_o,
  input logic [6:0]      status_o,
  input logic            dbg_enter_o,
  input logic            tlb_flush_o
);
  assert_exc_taken_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(exc_req_i) && !$past(rst)) |-> trap_o);

  assert_stack_super_R7: assert property (@(posedge clk) disable iff (rst)
    (trap_o && !dbg_enter_o && priv_o == PRIV_S) |->
      (!status_o[ST_SIE] && status_o[ST_SPP] == $past(priv_i[0])));

  assert_stack_mach_R8: assert property (@(posedge clk) disable iff (rst)
    (trap_o && !dbg_enter_o && priv_o == PRIV_M) |->
      (!status_o[ST_MIE] && status_o[ST_MPP +: 2] == $past(priv_i)));

  assert_debug_rom_R10: assert property (@(posedge clk) disable iff (rst)
    dbg_enter_o |-> (trap_o && priv_o == PRIV_M && pc_o == DBG_ROM));

  assert_flush_change_R11: assert property (@(posedge clk) disable iff (rst)
    tlb_flush_o |-> (trap_o && priv_o != $past(priv_i)));

  assert_no_flush_same_R11: assert property (@(posedge clk) disable iff (rst)
    (trap_o && !tlb_flush_o) |-> (priv_o == $past(priv_i)));

  assert_follow_R12: assert property (@(posedge clk) disable iff (rst)
    (!trap_o && !$past(rst)) |-> (priv_o == $past(priv_i) && status_o == $past(status_i)));
endmodule

bind trap_entry trap_entry_chk #(.XLEN(XLEN), .DBG_ROM(DBG_ROM)) u_trap_entry_chk (
  .clk        (clk),
  .rst        (rst),
  .priv_i     (priv_i),
  .status_i   (status_i),
  .exc_req_i  (exc_req_i),
  .trap_o     (trap_o),
  .pc_o       (pc_o),
  .priv_o     (priv_o),
  .status_o   (status_o),
  .dbg_enter_o(dbg_enter_o),
  .tlb_flush_o(tlb_flush_o)
);

// File: tb/trap_entry_bench.sv
`timescale 1ns/1ps
module trap_entry_bench;
  localparam int XLEN = 32;
  localparam int NIRQ = 12;
  localparam int CW   = 6;
  localparam logic [31:0] ROM = 32'h800;

  logic clk = 0;
  logic rst = 1;
  always #4 clk = ~clk;

  logic [1:0]      priv_i;
  logic [6:0]      status_i;
  logic [NIRQ-1:0] irq_pend_i, irq_en_i, irq_deleg_i;
  logic [XLEN-1:0] exc_deleg_i, mtvec_i, stvec_i, epc_i, exc_addr_i;
  logic            exc_req_i, exc_has_addr_i, dbg_attached_i;
  logic [CW-1:0]   exc_cause_i;
  logic            trap_o, dbg_enter_o, tlb_flush_o;
  logic [XLEN-1:0] pc_o, mcause_o, mepc_o, mbad_o, scause_o, sepc_o, sbad_o, dpc_o;
  logic [1:0]      priv_o, dbg_prv_o;
  logic [6:0]      status_o;
  logic [2:0]      dbg_cause_o;

  trap_entry u_trap_entry (.*);

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // bench model state
  logic [31:0] m_pc, m_mcause, m_mepc, m_mbad, m_scause, m_sepc, m_sbad, m_dpc;
  logic [1:0]  m_priv, m_dprv;
  logic [6:0]  m_st;
  logic [2:0]  m_dcause;
  logic        m_trap, m_dbg, m_flush;
  int          kind;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pc = 0; m_mcause = 0; m_mepc = 0; m_mbad = 0; m_scause = 0; m_sepc = 0;
    m_sbad = 0; m_dpc = 0; m_priv = 2'd3; m_dprv = 0; m_st = 0; m_dcause = 0;
    m_trap = 0; m_dbg = 0; m_flush = 0; kind = 0;
  endtask

  task automatic idle();
    priv_i = 2'd3; status_i = 0; irq_pend_i = 0; irq_en_i = 0; irq_deleg_i = 0;
    exc_deleg_i = 0; mtvec_i = 32'h100; stvec_i = 32'h200; epc_i = 32'h4000;
    exc_req_i = 0; exc_cause_i = 0; exc_has_addr_i = 0; exc_addr_i = 0; dbg_attached_i = 0;
  endtask

  task automatic predict();
    int win;
    int idx;
    logic [31:0] dm, cause;
    logic has, pie, tos;
    win = -1;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      logic ok;
      if (irq_deleg_i[i]) ok = (priv_i == 2'd0) || (priv_i == 2'd1 && status_i[0]);
      else ok = (priv_i != 2'd3) || status_i[1];
      if (irq_pend_i[i] && irq_en_i[i] && ok) win = i;
    end
    kind = 0; idx = 0; dm = 0; cause = 0; has = 0;
    if (exc_req_i) begin
      if (exc_cause_i == 6'd3 && dbg_attached_i) kind = 1;
      else begin kind = 4; idx = exc_cause_i; dm = exc_deleg_i; cause = {26'd0, exc_cause_i}; has = exc_has_addr_i; end
    end else if (win >= 0) begin
      kind = 4; idx = win; dm = {20'd0, irq_deleg_i}; cause = 32'h8000_0000 | win;
    end
    pie = (priv_i == 2'd3) ? status_i[1] : (priv_i == 2'd1) ? status_i[0] : 1'b0;
    m_st = status_i; m_dbg = (kind == 1); m_trap = (kind != 0);
    if (kind == 4) begin
      tos = (priv_i <= 2'd1) && (idx < 32) && dm[idx];
      kind = tos ? 2 : 3;
    end
    case (kind)
      1: begin m_pc = ROM; m_dcause = 3'd1; m_dprv = priv_i; m_dpc = epc_i; m_priv = 2'd3; end
      2: begin m_pc = stvec_i; m_scause = cause; m_sepc = epc_i; if (has) m_sbad = exc_addr_i;
               m_st[2] = pie; m_st[4] = priv_i[0]; m_st[0] = 0; m_priv = 2'd1; end
      3: begin m_pc = mtvec_i; m_mcause = cause; m_mepc = epc_i; if (has) m_mbad = exc_addr_i;
               m_st[3] = pie; m_st[6:5] = priv_i; m_st[1] = 0; m_priv = 2'd3; end
      default: m_priv = priv_i;
    endcase
    m_flush = (kind != 0) && (m_priv != priv_i);
  endtask

  task automatic compare();
    string t;
    t = (kind == 2) ? "R7" : (kind == 3) ? "R8" : (kind == 1) ? "R10" : "R12";
    chk(trap_o, m_trap, "R5 trap pulse");
    chk(pc_o, m_pc, {t, " pc"});
    chk(priv_o, m_priv, {t, " priv"});
    chk(status_o, m_st, {t, " status"});
    chk(mcause_o, m_mcause, "R8 mcause");
    chk(mepc_o, m_mepc, "R8 mepc");
    chk(scause_o, m_scause, "R7 scause");
    chk(sepc_o, m_sepc, "R7 sepc");
    chk(mbad_o, m_mbad, "R9 mbad");
    chk(sbad_o, m_sbad, "R9 sbad");
    chk(dbg_enter_o, m_dbg, "R10 dbg enter");
    chk(dbg_cause_o, m_dcause, "R10 dbg cause");
    chk(dbg_prv_o, m_dprv, "R10 dbg prv");
    chk(dpc_o, m_dpc, "R10 dpc");
    chk(tlb_flush_o, m_flush, "R11 flush");
  endtask

  task automatic step();
    predict();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R5 watchdog act=hung exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    idle();
    model_reset();
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(priv_o, 2'd3, "R1 priv");
    chk(status_o, 0, "R1 status");
    chk(trap_o, 0, "R1 trap");
    chk(tlb_flush_o, 0, "R1 flush");
    chk(mcause_o, 0, "R1 mcause");
    chk(pc_o, 0, "R1 pc");
    rst = 0;

    // R2: machine-level line masked by MIE
    idle(); irq_pend_i = 12'h020; irq_en_i = 12'h020; step();
    chk(trap_o, 0, "R2 masked at M");
    status_i = 7'b0000010; step();
    chk(mcause_o, 32'h8000_0005, "R2 taken at M");

    // R3: delegated line
    idle(); priv_i = 2'd1; irq_pend_i = 12'h004; irq_en_i = 12'h004; irq_deleg_i = 12'h004; step();
    chk(trap_o, 0, "R3 masked at S");
    priv_i = 2'd3; status_i = 7'b0000011; step();
    chk(trap_o, 0, "R3 never at M");
    priv_i = 2'd0; status_i = 0; step();
    chk(scause_o, 32'h8000_0002, "R3 taken from U");

    // R4: lowest line wins
    idle(); priv_i = 2'd0; irq_pend_i = 12'h288; irq_en_i = 12'hFFF; step();
    chk(mcause_o, 32'h8000_0003, "R4 lowest line");

    // R5: exception beats interrupt
    idle(); priv_i = 2'd0; irq_pend_i = 12'h001; irq_en_i = 12'h001;
    exc_req_i = 1; exc_cause_i = 6'd2; step();
    chk(mcause_o, 32'd2, "R5 exception first");

    // R6: index range and delegation
    idle(); priv_i = 2'd0; exc_deleg_i = 32'hFFFF_FFFF; exc_req_i = 1; exc_cause_i = 6'd40; step();
    chk(priv_o, 2'd3, "R6 index beyond XLEN");
    exc_cause_i = 6'd13; step();
    chk(priv_o, 2'd1, "R6 delegated");

    // R9: address kept when absent
    idle(); exc_req_i = 1; exc_cause_i = 6'd5; exc_has_addr_i = 1; exc_addr_i = 32'hDEAD_0000; step();
    exc_has_addr_i = 0; exc_addr_i = 32'h1234_5678; step();
    chk(mbad_o, 32'hDEAD_0000, "R9 hold bad addr");

    // R10: breakpoint with and without debugger
    idle(); priv_i = 2'd0; exc_req_i = 1; exc_cause_i = 6'd3; dbg_attached_i = 1; epc_i = 32'h5550; step();
    chk(pc_o, ROM, "R10 debug rom");
    dbg_attached_i = 0; step();
    chk(mcause_o, 32'd3, "R10 plain breakpoint");

    // R11: same-privilege trap does not flush
    idle(); exc_req_i = 1; exc_cause_i = 6'd8; step();
    chk(tlb_flush_o, 0, "R11 no change");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 2);
      priv_i = (r == 2) ? 2'd3 : 2'(r);
      status_i = 7'($urandom());
      irq_pend_i = 12'($urandom()) & 12'($urandom());
      irq_en_i = 12'($urandom());
      irq_deleg_i = 12'($urandom());
      exc_deleg_i = $urandom();
      mtvec_i = $urandom(); stvec_i = $urandom(); epc_i = $urandom();
      exc_req_i = ($urandom_range(0, 9) < 3);
      exc_cause_i = ($urandom_range(0, 3) == 0) ? 6'd3 : 6'($urandom());
      exc_has_addr_i = 1'($urandom());
      exc_addr_i = $urandom();
      dbg_attached_i = 1'($urandom());
      step();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule